// File: doc/BRIEF.md
# Hamming-Protected Serial Sample Sender

This block takes one 16-bit audio sample at a time over a valid/ready handshake and sends it out on a single serial wire. The sample is cut into its high byte and its low byte. Each byte is turned into a 13-bit single-error-correcting, double-error-detecting codeword: a Hamming(12,8) word plus one overall even-parity bit. Each codeword then travels inside its own asynchronous frame, with a low start bit in front and a high stop bit behind.

Bit timing comes from the master clock. With the default of 8 clocks per bit on a 12.288 MHz clock, the line runs at 1.536 Mbit/s. A whole sample is two 15-bit frames, 30 bit periods or 240 clocks, which fits inside one 48 kHz sample slot of 256 clocks. While a sample is on the wire the block holds ready low, so a new sample waits at the input and is never lost. Between samples the line rests high.

Top module: `secded_serial_tx`

## Requirements
- R1: The high byte (in_data[15:8]) is encoded and sent in the first frame, and the low byte (in_data[7:0]) in the second. Each byte is encoded on its own.
- R2: Codeword positions 1 to 12 hold p1, p2, d0, p4, d1, d2, d3, p8, d4, d5, d6, d7, where dN is bit N of the byte. p1 is the XOR of the byte bits masked by 8'h5B, p2 by 8'h6D, p4 by 8'h8E and p8 by 8'hF0.
- R3: Codeword position 13 is set so that all 13 codeword bits XOR to zero (even parity).
- R4: Each frame is a 0 start bit, then codeword positions 1 to 13 in ascending order, then a 1 stop bit.
- R5: Every bit, including the start and stop bits, lasts exactly CLKS_PER_BIT (8) clock cycles, and the line changes only at bit boundaries.
- R6: The second frame's start bit follows the first frame's stop bit with no gap, so a sample occupies 30 consecutive bit periods.
- R7: After reset, and whenever no sample is being sent, tx_line is 1 and in_ready is 1.
- R8: A sample is accepted on a clock edge where in_valid and in_ready are both 1. The start bit appears right after that edge. in_ready stays 0 for exactly 240 cycles from that edge.
- R9: A sample offered while in_ready is 0 is taken once in_ready returns to 1, and it is sent in full.
- R10: Changes on in_data or in_valid while a sample is being sent have no effect on the bits of that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 16 | Audio sample |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The checker assumes that a source which raises in_valid keeps it raised until in_ready takes the sample. It checks this assumption as part of the backpressure contract. The cycle counter it uses to place start, stop and bit-boundary checks begins only at an accept edge, so it takes for granted that the first accept comes after reset has been released. The bench only drives inputs on falling edges. It keeps in_valid high without a break from the moment it offers a sample until that sample is taken, and it changes in_data only while a sample is already in flight, so the source contract is never broken.

// File: rtl/secded_tx_pkg.sv
package secded_tx_pkg;

   // Number of Hamming check bits needed to cover k data bits.
   function automatic int ham_check_bits(input int k);
      int r;
      r = 0;
      while ((1 << r) < (k + r + 1)) r++;
      return r;
   endfunction

   // Width of one coded word: data, check bits and one overall parity bit.
   function automatic int coded_width(input int k);
      return k + ham_check_bits(k) + 1;
   endfunction

endpackage

// File: rtl/secded_byte_enc.sv
module secded_byte_enc
   import secded_tx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]               din,
   output logic [coded_width(BYTE_W)-1:0]  cw
);
   localparam int CHK_W = ham_check_bits(BYTE_W);
   localparam int HAM_N = BYTE_W + CHK_W;

   logic [HAM_N:1] pos;

   always_comb begin
      int di;
      logic acc;
      pos = '0;
      di  = 0;
      // data bits fill every position that is not a power of two
      for (int p = 1; p <= HAM_N; p++) begin
         if ((p & (p - 1)) != 0) begin
            pos[p] = din[di];
            di++;
         end
      end
      // check bit r covers every position with bit r of its index set
      for (int r = 0; r < CHK_W; r++) begin
         acc = 1'b0;
         for (int p = 1; p <= HAM_N; p++) begin
            if (((p >> r) & 1) == 1) acc = acc ^ pos[p];
         end
         pos[1 << r] = acc;
      end
      cw = {^pos, pos};
   end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
   parameter int CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CLKS_PER_BIT - 1);
   localparam bit POW2 = ((CLKS_PER_BIT & (CLKS_PER_BIT - 1)) == 0);

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == '0);

   generate
      if (POW2) begin : g_wrap
         // power-of-two period: the down-counter wraps by itself
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (load) cnt <= RELOAD;
            else if (run)  cnt <= cnt - 1'b1;
         end
      end else begin : g_reload
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (load) cnt <= RELOAD;
            else if (run)  cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq #(
   parameter int TOTAL_BITS = 30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [TOTAL_BITS-1:0] load_bits,
   input  logic                  tick,
   output logic                  line,
   output logic                  busy
);
   localparam int IDX_W = $clog2(TOTAL_BITS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL_BITS - 1);

   logic [TOTAL_BITS-1:0] sreg;
   logic [IDX_W-1:0]      idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= 1'b1;
         busy <= 1'b0;
         sreg <= '1;
         idx  <= '0;
      end else if (load) begin
         line <= load_bits[0];
         sreg <= {1'b1, load_bits[TOTAL_BITS-1:1]};
         idx  <= '0;
         busy <= 1'b1;
      end else if (tick) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            line <= 1'b1;
         end else begin
            line <= sreg[0];
            sreg <= {1'b1, sreg[TOTAL_BITS-1:1]};
            idx  <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/secded_serial_tx.sv
module secded_serial_tx
   import secded_tx_pkg::*;
#(
   parameter int SAMPLE_W     = 16,
   parameter int BYTE_W       = 8,
   parameter int CLKS_PER_BIT = 8,
   parameter bit HIGH_FIRST   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                tx_line
);
   localparam int N_BYTES    = SAMPLE_W / BYTE_W;
   localparam int CW_W       = coded_width(BYTE_W);
   localparam int FRAME_W    = CW_W + 2;
   localparam int TOTAL_BITS = FRAME_W * N_BYTES;

   generate
      if (SAMPLE_W % BYTE_W != 0) begin : g_bad_split
         $error("SAMPLE_W must be a whole number of bytes");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
      if (CLKS_PER_BIT < 2) begin : g_bad_rate
         $error("CLKS_PER_BIT must be at least 2");
      end
   endgenerate

   logic [CW_W-1:0]       cw_arr [N_BYTES];
   logic [TOTAL_BITS-1:0] frame_bits;
   logic                  busy;
   logic                  accept;
   logic                  tick;

   genvar g;
   generate
      for (g = 0; g < N_BYTES; g++) begin : g_enc
         secded_byte_enc #(.BYTE_W(BYTE_W)) u_enc (
            .din (in_data[g*BYTE_W +: BYTE_W]),
            .cw  (cw_arr[g])
         );
      end
      for (g = 0; g < N_BYTES; g++) begin : g_slot
         localparam int SRC = HIGH_FIRST ? (N_BYTES - 1 - g) : g;
         assign frame_bits[g*FRAME_W +: FRAME_W] = {1'b1, cw_arr[SRC], 1'b0};
      end
   endgenerate

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .run   (busy),
      .tick  (tick)
   );

   tx_frame_seq #(.TOTAL_BITS(TOTAL_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_bits (frame_bits),
      .tick      (tick),
      .line      (tx_line),
      .busy      (busy)
   );

endmodule

// File: rtl/secded_serial_tx_chk.sv
module secded_serial_tx_chk
   import secded_tx_pkg::*;
#(
   parameter int SAMPLE_W     = 16,
   parameter int BYTE_W       = 8,
   parameter int CLKS_PER_BIT = 8
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic tx_line
);
   localparam int FRAME_W  = coded_width(BYTE_W) + 2;
   localparam int TOT_CYC  = FRAME_W * (SAMPLE_W / BYTE_W) * CLKS_PER_BIT;

   // cyc = 1 + clock edges since the accepting edge
   int cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cyc <= 0;
      else if (in_valid && in_ready)  cyc <= 1;
      else if (!in_ready)             cyc <= cyc + 1;
   end

   assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> tx_line);

   assert_start_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!tx_line && !in_ready));

   assert_ready_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> (cyc == TOT_CYC + 1));

   assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && cyc > 0 && ((cyc - 1) % CLKS_PER_BIT) != 0) |-> $stable(tx_line));

   assert_first_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && cyc > 0 && ((cyc - 1) / CLKS_PER_BIT) == FRAME_W - 1) |-> tx_line);

   assert_second_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && cyc > 0 && ((cyc - 1) / CLKS_PER_BIT) == FRAME_W) |-> !tx_line);

   assert_src_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> in_valid);

endmodule

bind secded_serial_tx secded_serial_tx_chk #(
   .SAMPLE_W     (SAMPLE_W),
   .BYTE_W       (BYTE_W),
   .CLKS_PER_BIT (CLKS_PER_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tx_line  (tx_line)
);

// File: tb/test_secded_serial_tx.sv
`timescale 1ns/1ps
module test_secded_serial_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        tx_line;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   secded_serial_tx i_secded_serial_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .tx_line  (tx_line)
   );

   function automatic logic [12:0] enc13(input logic [7:0] d);
      logic [12:0] c;
      c[0]  = ^(d & 8'h5B);
      c[1]  = ^(d & 8'h6D);
      c[2]  = d[0];
      c[3]  = ^(d & 8'h8E);
      c[4]  = d[1];
      c[5]  = d[2];
      c[6]  = d[3];
      c[7]  = ^(d & 8'hF0);
      c[8]  = d[4];
      c[9]  = d[5];
      c[10] = d[6];
      c[11] = d[7];
      c[12] = ^c[11:0];
      return c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // offers in_data at a falling edge; returns at the falling edge after the accept edge
   task automatic wait_accept();
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic offer(input logic [15:0] s);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = s;
      wait_accept();
   endtask

   // called at the falling edge right after the accept edge; samples each bit mid-period
   task automatic capture(output logic [29:0] v);
      repeat (3) @(posedge clk);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         v[k] = tx_line;
         if (k < 29) repeat (8) @(posedge clk);
      end
   endtask

   task automatic judge(input logic [29:0] v, input logic [15:0] s);
      check("R4 first start", 32'(v[0]), 32'(1'b0));
      check("R1 R2 high byte codeword", 32'(v[13:1]), 32'(enc13(s[15:8])));
      check("R3 first parity", 32'(^v[13:1]), 32'(1'b0));
      check("R4 first stop", 32'(v[14]), 32'(1'b1));
      check("R6 second start", 32'(v[15]), 32'(1'b0));
      check("R1 R2 low byte codeword", 32'(v[28:16]), 32'(enc13(s[7:0])));
      check("R3 second parity", 32'(^v[28:16]), 32'(1'b0));
      check("R4 second stop", 32'(v[29]), 32'(1'b1));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R7 line in reset", 32'(tx_line), 32'(1'b1));
      check("R7 ready in reset", 32'(in_ready), 32'(1'b1));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 line after reset", 32'(tx_line), 32'(1'b1));
      check("R7 ready after reset", 32'(in_ready), 32'(1'b1));
   endtask

   task automatic t_pattern(input logic [15:0] s);
      logic [29:0] v;
      offer(s);
      check("R8 ready low after accept", 32'(in_ready), 32'(1'b0));
      capture(v);
      judge(v, s);
      repeat (8) @(negedge clk);
      check("R7 idle line", 32'(tx_line), 32'(1'b1));
   endtask

   task automatic t_bit_period();
      int n;
      offer(16'h0000);
      n = 0;
      while (!tx_line) begin n++; @(negedge clk); end
      check("R5 low run of start plus zero codeword", 32'(n), 32'd112);
      n = 0;
      while (tx_line) begin n++; @(negedge clk); end
      check("R5 R6 stop bit width before second start", 32'(n), 32'd8);
      while (!in_ready) @(negedge clk);
   endtask

   task automatic t_ready_window();
      int n;
      offer(16'h3C5A);
      n = 0;
      while (!in_ready) begin n++; @(negedge clk); end
      check("R8 ready low cycles", 32'(n), 32'd240);
      check("R7 line high when ready returns", 32'(tx_line), 32'(1'b1));
   endtask

   task automatic t_backpressure();
      logic [29:0] va;
      logic [29:0] vb;
      offer(16'hC3A1);
      in_valid = 1'b1;
      in_data  = 16'h5E07;
      capture(va);
      check("R8 ready still low late in sample", 32'(in_ready), 32'(1'b0));
      judge(va, 16'hC3A1);
      check("R10 first sample unchanged by new data", 32'(va[13:1]), 32'(enc13(8'hC3)));
      wait_accept();
      capture(vb);
      judge(vb, 16'h5E07);
      check("R9 held sample delivered", 32'(vb[28:16]), 32'(enc13(8'h07)));
      while (!in_ready) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_pattern(16'h0000);
      t_pattern(16'hFFFF);
      t_pattern(16'hA55A);
      t_pattern(16'h1234);
      t_pattern(16'h8001);
      t_bit_period();
      t_ready_window();
      t_backpressure();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule